// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs external memory and peripheral transfers for a small 8-bit processor core over a bus that carries the address and the data on the same lines. The core offers a request: a 13-bit address, a write flag, write data and an opcode-fetch flag. The controller takes the request when `req_ready` is high. It then runs one fixed bus cycle of five clocks. The top five address bits go out on dedicated lines. The low byte goes out on the shared bus, flagged by an address strobe. The data moves later on the same lines, flagged by a data strobe.

A read/write line tells the peripheral the direction of each transfer. For a read, the controller samples the shared bus at the moment the data strobe falls and hands the byte to the core. A one-clock `done` pulse marks the end of every cycle. A load-instruction flag marks the whole of an opcode-fetch cycle. A halt input stops the controller from taking new work, which models the low-power modes of the processor.

The sequencer has six named states:

| State | Phase | Bus activity |
|---|---|---|
| `PH_IDLE` | none | no cycle in progress |
| `PH_ADDR` | 0 | address strobe high; the low address byte is driven |
| `PH_HOLD` | 1 | the low address byte is still driven; strobes low |
| `PH_TURN` | 2 | turnaround; write data is driven on a write, the bus is released on a read |
| `PH_DATA0` | 3 | first clock of the data strobe |
| `PH_DATA1` | 4 | second clock of the data strobe; the read sample is taken at its closing edge |

Its transitions are:

- `PH_IDLE` goes to `PH_ADDR` when a request is taken, and stays in `PH_IDLE` otherwise.
- `PH_ADDR` goes to `PH_HOLD`, `PH_HOLD` goes to `PH_TURN`, `PH_TURN` goes to `PH_DATA0`, and `PH_DATA0` goes to `PH_DATA1`. These four steps are unconditional.
- `PH_DATA1` goes to `PH_ADDR` when a request is taken, giving back-to-back cycles. Otherwise it returns to `PH_IDLE`.

Top module: `mux_bus_ctrl`

## Requirements
- R1: `req_ready` is high exactly when `halt` is low and the state is `PH_IDLE` or `PH_DATA1`. A request is taken at a clock edge where both `req_valid` and `req_ready` are high. It is followed by exactly five clocks in the order `PH_ADDR`, `PH_HOLD`, `PH_TURN`, `PH_DATA0`, `PH_DATA1`. With `req_valid` held high, the next cycle's `PH_ADDR` follows `PH_DATA1` directly, so address strobes come every five clocks.
- R2: `as_o` is high only during `PH_ADDR`, for one clock. `ds_o` is high only during `PH_DATA0` and `PH_DATA1`, for two clocks. The two strobes are never high together.
- R3: Throughout a cycle, `addr_hi_o` equals bits 12:8 of the taken address. During `PH_ADDR` and `PH_HOLD`, `bus_oe_o` is high and `bus_out_o` equals address bits 7:0.
- R4: `rw_o` is 1 for a read and 0 for a write. It holds one value from `PH_ADDR` through `PH_DATA1`, so it is constant across the data strobe. It is 1 in `PH_IDLE`.
- R5: On a write, `bus_oe_o` is high and `bus_out_o` equals the write data from `PH_TURN` through `PH_DATA1`.
- R6: On a read, `bus_oe_o` is low from `PH_TURN` through `PH_DATA1`. `rd_data_o` takes the value of `bus_in_i` sampled at the clock edge that ends `PH_DATA1`, which is the falling edge of the data strobe. A write cycle leaves `rd_data_o` unchanged.
- R7: `done_o` is high for exactly one clock, the clock after `PH_DATA1`, for both reads and writes.
- R8: `li_o` is high for all five clocks of a read cycle whose fetch flag was set. It is low at all other times, including a write cycle that was requested with the fetch flag set.
- R9: While `halt` is high, `req_ready` is low and no new cycle starts. A cycle already in progress runs to the end and still pulses `done_o`.
- R10: While `rst_n` is low and after its release, the state is `PH_IDLE` with `as_o`, `ds_o`, `bus_oe_o`, `li_o` and `done_o` low, `rw_o` high, `addr_hi_o` zero and `rd_data_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one bus phase per clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt | input | 1 | Blocks new cycles (low-power modes) |
| req_valid | input | 1 | Core has a request |
| req_ready | output | 1 | Request taken at this edge if valid |
| req_addr | input | 13 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| req_fetch | input | 1 | Request is an opcode fetch |
| rd_data_o | output | 8 | Last byte read |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| rw_o | output | 1 | 1 = read, 0 = write |
| li_o | output | 1 | Load-instruction flag |
| addr_hi_o | output | 5 | Address bits 12:8 |
| bus_out_o | output | 8 | Shared bus output value |
| bus_oe_o | output | 1 | Shared bus output enable |
| bus_in_i | input | 8 | Shared bus input value |

## Verification
The bench runs a write and then a read to the same address back to back, with `req_valid` held high. A controller that idled between cycles, or that sampled the read byte a clock early or late, would return the wrong byte or misplace the second address strobe. It raises `halt` in the middle of a cycle. A design that dropped the cycle would miss `done_o`, and one that ignored `halt` would start a second strobe. It also issues a write with the fetch flag set and a write after a read. A controller that did not qualify the flag with the direction would raise `li_o`, and one that sampled on every cycle end would overwrite `rd_data_o`. A monitor flags any overlap of the two strobes and any change of `rw_o` while the data strobe is high.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_HOLD  = 3'd2,
        PH_TURN  = 3'd3,
        PH_DATA0 = 3'd4,
        PH_DATA1 = 3'd5
    } phase_t;
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_fetch,
    output logic              req_ready,
    output phase_t            state_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              wr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              fetch_q
);
    phase_t state_d;
    logic   accept;

    assign req_ready = !halt && (state_q == PH_IDLE || state_q == PH_DATA1);
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:  state_d = accept ? PH_ADDR : PH_IDLE;
            PH_ADDR:  state_d = PH_HOLD;
            PH_HOLD:  state_d = PH_TURN;
            PH_TURN:  state_d = PH_DATA0;
            PH_DATA0: state_d = PH_DATA1;
            PH_DATA1: state_d = accept ? PH_ADDR : PH_IDLE;
            default:  state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            fetch_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            fetch_q <= req_fetch;
        end
    end

    // R1: a cycle, once begun, walks its phases in order
    a_r1_addr_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PH_ADDR |=> state_q == PH_HOLD);
    a_r1_turn_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PH_TURN |=> state_q == PH_DATA0);
    // R9: halted and idle means still idle on the next clock
    a_r9_halt_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && state_q == PH_IDLE) |=> state_q == PH_IDLE);
endmodule

// File: rtl/mbc_drive.sv
module mbc_drive
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            state_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              wr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              fetch_q,
    output logic              as_o,
    output logic              ds_o,
    output logic              rw_o,
    output logic              li_o,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic [DATA_W-1:0] bus_out_o,
    output logic              bus_oe_o
);
    logic in_cycle;
    logic addr_phase;

    assign in_cycle   = (state_q != PH_IDLE);
    assign addr_phase = (state_q == PH_ADDR) || (state_q == PH_HOLD);
    assign addr_hi_o  = addr_q[ADDR_W-1:DATA_W];

    always_comb begin
        as_o      = 1'b0;
        ds_o      = 1'b0;
        rw_o      = 1'b1;
        li_o      = 1'b0;
        bus_oe_o  = 1'b0;
        bus_out_o = wdata_q;
        unique case (state_q)
            PH_IDLE: begin
            end
            PH_ADDR: begin
                as_o = 1'b1;
            end
            PH_HOLD, PH_TURN: begin
            end
            PH_DATA0, PH_DATA1: begin
                ds_o = 1'b1;
            end
            default: begin
            end
        endcase
        if (in_cycle) begin
            rw_o     = !wr_q;
            li_o     = fetch_q && !wr_q;
            bus_oe_o = addr_phase || wr_q;
        end
        if (addr_phase) begin
            bus_out_o = addr_q[DATA_W-1:0];
        end
    end

    // R2: strobes never overlap
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(as_o && ds_o));
    // R4: direction is held across the data strobe
    a_r4_rw_stable_in_ds: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o && $past(ds_o)) |-> $stable(rw_o));
    // R6: the controller never fights the bus during read data
    a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_o && rw_o) |-> !bus_oe_o);
    // R2: address strobe is a single clock
    a_r2_as_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        as_o |=> !as_o);
endmodule

// File: rtl/mbc_capture.sv
module mbc_capture
    import mbc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            state_q,
    input  logic              wr_q,
    input  logic [DATA_W-1:0] bus_in_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o
);
    logic strobe_end;

    assign strobe_end = (state_q == PH_DATA1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= strobe_end;
            if (strobe_end && !wr_q) begin
                rd_data_o <= bus_in_i;
            end
        end
    end

    // R7: done is a single-clock pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6: a write cycle does not disturb the read register
    a_r6_write_keeps_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_end && wr_q) |=> $stable(rd_data_o));
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_fetch,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o,
    output logic              as_o,
    output logic              ds_o,
    output logic              rw_o,
    output logic              li_o,
    output logic [HI_W-1:0]   addr_hi_o,
    output logic [DATA_W-1:0] bus_out_o,
    output logic              bus_oe_o,
    input  logic [DATA_W-1:0] bus_in_i
);
    phase_t            state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              fetch_q;

    mbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (halt),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .req_fetch (req_fetch),
        .req_ready (req_ready),
        .state_q   (state_q),
        .addr_q    (addr_q),
        .wr_q      (wr_q),
        .wdata_q   (wdata_q),
        .fetch_q   (fetch_q)
    );

    mbc_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) drive_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .addr_q    (addr_q),
        .wr_q      (wr_q),
        .wdata_q   (wdata_q),
        .fetch_q   (fetch_q),
        .as_o      (as_o),
        .ds_o      (ds_o),
        .rw_o      (rw_o),
        .li_o      (li_o),
        .addr_hi_o (addr_hi_o),
        .bus_out_o (bus_out_o),
        .bus_oe_o  (bus_oe_o)
    );

    mbc_capture #(.DATA_W(DATA_W)) capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .wr_q      (wr_q),
        .bus_in_i  (bus_in_i),
        .rd_data_o (rd_data_o),
        .done_o    (done_o)
    );

    // R7: every data strobe ending is followed by done
    a_r7_done_after_ds: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_o) |-> done_o);
endmodule

// File: tb/mux_bus_ctrl_tb_top.sv
module mux_bus_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [12:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_fetch = 1'b0;
    logic [7:0]  rd_data_o;
    logic        done_o, as_o, ds_o, rw_o, li_o, bus_oe_o;
    logic [4:0]  addr_hi_o;
    logic [7:0]  bus_out_o;
    logic [7:0]  bus_in_i;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0]  last_rd = 8'h00;

    always #5 clk = ~clk;

    mux_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .halt(halt), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_fetch(req_fetch), .rd_data_o(rd_data_o),
        .done_o(done_o), .as_o(as_o), .ds_o(ds_o), .rw_o(rw_o), .li_o(li_o),
        .addr_hi_o(addr_hi_o), .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o),
        .bus_in_i(bus_in_i)
    );

    // External memory model: address latched during the address strobe
    logic [12:0] lat_addr;
    logic [7:0]  mem [64];
    logic        prev_ds = 1'b0;
    logic        prev_rw = 1'b1;

    assign bus_in_i = (ds_o && rw_o) ? mem[lat_addr[5:0]] : 8'h00;

    always @(negedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
        end else begin
            if (as_o) lat_addr <= {addr_hi_o, bus_out_o};
            if (ds_o && !rw_o) mem[lat_addr[5:0]] <= bus_out_o;
            if (as_o && ds_o) begin
                n_errors++;
                $display("FAIL R2: strobes overlap actual 1 expected 0");
            end
            if (ds_o && prev_ds && rw_o != prev_rw) begin
                n_errors++;
                $display("FAIL R4: rw moved in strobe actual %0b expected %0b", rw_o, prev_rw);
            end
        end
        prev_ds <= ds_o;
        prev_rw <= rw_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_phase(input int p, input logic [12:0] a, input logic w,
                               input logic [7:0] d, input logic f);
        chk("R2 as", as_o, p == 0);
        chk("R2 ds", ds_o, p >= 3);
        chk("R3 addr_hi", addr_hi_o, a[12:8]);
        chk("R4 rw", rw_o, !w);
        chk("R8 li", li_o, f && !w);
        chk("R5/R6 oe", bus_oe_o, (p < 2) || w);
        if (p < 2) chk("R3 low addr", bus_out_o, a[7:0]);
        else if (w) chk("R5 wdata", bus_out_o, d);
    endtask

    // One complete cycle; entered and left at a falling clock edge
    task automatic run_cycle(input logic [12:0] a, input logic w, input logic [7:0] d,
                             input logic f);
        req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = d; req_fetch = f;
        while (!req_ready) @(negedge clk);
        chk("R1 ready", req_ready, 1);
        for (int p = 0; p < 5; p++) begin
            @(negedge clk);
            if (p == 0) req_valid = 1'b0;
            check_phase(p, a, w, d, f);
        end
        @(negedge clk);
        chk("R7 done", done_o, 1);
        chk("R1 back to idle", as_o, 0);
        if (!w) last_rd = mem[a[5:0]];
        chk("R6 rd_data", rd_data_o, last_rd);
        @(negedge clk);
        chk("R7 done width", done_o, 0);
    endtask

    task automatic test_reset();
        chk("R10 as", as_o, 0);
        chk("R10 ds", ds_o, 0);
        chk("R10 rw", rw_o, 1);
        chk("R10 oe", bus_oe_o, 0);
        chk("R10 li", li_o, 0);
        chk("R10 done", done_o, 0);
        chk("R10 addr_hi", addr_hi_o, 0);
        chk("R10 rd_data", rd_data_o, 0);
        chk("R1 ready idle", req_ready, 1);
    endtask

    task automatic test_write_read();
        run_cycle(13'h1A05, 1'b1, 8'hC3, 1'b0);
        run_cycle(13'h0B11, 1'b1, 8'h5E, 1'b0);
        run_cycle(13'h1A05, 1'b0, 8'h00, 1'b0);
        chk("R6 read back", rd_data_o, 8'hC3);
        run_cycle(13'h0B11, 1'b0, 8'h00, 1'b1);
        chk("R6 fetch read", rd_data_o, 8'h5E);
        // write with fetch flag: li stays low (R8), rd_data kept (R6)
        run_cycle(13'h0322, 1'b1, 8'h77, 1'b1);
        chk("R6 write keeps rd", rd_data_o, 8'h5E);
    endtask

    task automatic test_back_to_back();
        req_valid = 1'b1; req_addr = 13'h1F2A; req_write = 1'b1;
        req_wdata = 8'hA9; req_fetch = 1'b0;
        while (!req_ready) @(negedge clk);
        for (int k = 0; k <= 10; k++) begin
            @(negedge clk);
            if (k == 1) begin
                req_write = 1'b0; req_wdata = 8'h00;
            end
            if (k < 5) check_phase(k, 13'h1F2A, 1'b1, 8'hA9, 1'b0);
            else if (k < 10) check_phase(k - 5, 13'h1F2A, 1'b0, 8'h00, 1'b0);
            if (k == 5) begin
                chk("R1 b2b strobe", as_o, 1);
                chk("R7 done b2b", done_o, 1);
                req_valid = 1'b0;
            end
            if (k == 10) begin
                chk("R7 done second", done_o, 1);
                chk("R6 b2b read", rd_data_o, 8'hA9);
                chk("R1 idle after", as_o, 0);
            end
        end
        last_rd = 8'hA9;
        @(negedge clk);
    endtask

    task automatic test_halt();
        halt = 1'b1; req_valid = 1'b1; req_addr = 13'h0044;
        req_write = 1'b0; req_fetch = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R9 ready low", req_ready, 0);
            chk("R9 no strobe", as_o, 0);
        end
        halt = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        chk("R9 starts after release", as_o, 1);
        halt = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 5) begin
                chk("R9 done still", done_o, 1);
                chk("R9 no restart", as_o, 0);
            end
        end
        @(negedge clk);
        chk("R9 idle held", ds_o, 0);
        halt = 1'b0; req_valid = 1'b0;
        last_rd = mem[6'h04];
        chk("R6 halted read", rd_data_o, last_rd);
        @(negedge clk);
    endtask

    initial begin
        #(10 * 20000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_write_read();
        test_back_to_back();
        test_halt();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule